// File: doc/BRIEF.md
# Serial-MAC 3x3 Convolution Engine

This block slides three 3x3 kernels over a single-channel 8-bit grayscale image kept in a synchronous memory. It uses stride 1 and no padding. For every valid window position it produces one signed sum per kernel and stores each sum separately in a result memory. Each kernel has one multiply-accumulate lane with a single multiplier. The nine taps of a window are fed to that lane one per clock. A shared controller walks the window position row by row, from the top-left position to the bottom-right one.

A pulse on `start` begins a full pass over the image. The block issues image and weight reads with one cycle of read latency. Each window takes a fixed budget of fourteen cycles. After the last result is written, `done` pulses for one cycle, so that a downstream stage can use it as its own start.

Top module: `conv3x3_engine`

## Requirements
- R1: After reset, and until a start is accepted, `img_rd`, `wgt_rd`, `res_we` and `done` are all low.
- R2: Window cycle p runs from 0 to 8 and fetches tap p, with i = p/3 (kernel row) and j = p%3 (kernel column). Taps go left to right along each kernel row, rows top to bottom. For the window at output row r and column c, that cycle reads the image at address (r+i)*IMG_W + (c+j), and the weights at `wgt_addr` = p. Read data is returned one cycle after the address.
- R3: Each result is the exact sum over the nine taps of unsigned pixel times signed 8-bit weight. It is given as a 20-bit two's-complement `res_data` and never overflows the accumulator.
- R4: Result writes go to address ch*NWIN + r*OW + c, where OW = IMG_W-2 and NWIN = OW*(IMG_H-2). This is 676 for the default image.
- R5: Every window takes exactly 14 cycles, and windows run back to back. The fetches take cycles 0 to 8. Channels 0, 1 and 2 are written in cycles 10, 11 and 12, one write per cycle. Cycle 13 moves to the next window. Window positions advance column first, then row.
- R6: `done` is high for exactly one cycle. That cycle comes 14*NWIN cycles after the first cycle of the pass, and the block is idle afterwards.
- R7: A `start` pulse that arrives while a pass is running has no effect on the read or write sequence and causes no extra `done`.
- R8: A new `start` after `done` runs a complete new pass on the current memory contents.
- R9: The weight for channel ch is taken from bits [ch*8 +: 8] of `wgt_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| start | input | 1 | Pulse that begins a pass while the block is idle |
| img_rd | output | 1 | Image read enable |
| img_addr | output | 10 | Image read address |
| img_rdata | input | 8 | Image pixel, returned one cycle after the address |
| wgt_rd | output | 1 | Weight read enable |
| wgt_addr | output | 4 | Tap index of the weight read |
| wgt_rdata | input | 24 | Weights for all three channels at that tap, one byte per channel |
| res_we | output | 1 | Result write strobe |
| res_addr | output | 11 | Result write address |
| res_data | output | 20 | Signed result |
| done | output | 1 | One-cycle end-of-pass pulse |

## Verification
The bench builds the block with its default parameters: a 28x28 image, a 3x3 kernel and three channels. Every one of the 676 window positions is therefore checked in each pass, including the last column and the last row, where address wrap errors would show. One pass uses an all-white image with extreme positive and negative weights, which drives the accumulator to its largest magnitudes. A second pass uses a position-dependent image with mixed weights, which separates the tap order and the channel lanes.

// File: rtl/conv_pkg.sv
package conv_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_MAC,
    ST_WR,
    ST_STEP,
    ST_DONE
  } conv_state_e;

  function automatic int unsigned clog2_min1(input int unsigned v);
    return (v > 1) ? $clog2(v) : 1;
  endfunction

endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int unsigned IMG_W = 28,
  parameter int unsigned IMG_H = 28,
  parameter int unsigned K     = 3,
  parameter int unsigned NCH   = 3
) (
  input  logic                                        clk,
  input  logic                                        rst_n,
  input  logic                                        start,
  output logic                                        rd_en,
  output logic [clog2_min1(IMG_W*IMG_H)-1:0]          img_addr,
  output logic [clog2_min1(K*K+1)-1:0]                tap_idx,
  output logic                                        mac_clr,
  output logic                                        mac_en,
  output logic                                        wr_en,
  output logic [clog2_min1(NCH)-1:0]                  wr_ch,
  output logic [clog2_min1((IMG_W-K+1)*(IMG_H-K+1))-1:0] win_idx,
  output logic                                        done
);

  localparam int unsigned OW     = IMG_W - K + 1;
  localparam int unsigned OH     = IMG_H - K + 1;
  localparam int unsigned KK     = K * K;
  localparam int unsigned NWIN   = OW * OH;
  localparam int unsigned IMG_AW = clog2_min1(IMG_W * IMG_H);
  localparam int unsigned TAP_W  = clog2_min1(KK + 1);
  localparam int unsigned CHW    = clog2_min1(NCH);
  localparam int unsigned WIN_AW = clog2_min1(NWIN);
  localparam int unsigned COL_W  = clog2_min1(OW);
  localparam int unsigned JW     = clog2_min1(K);
  localparam int unsigned WIN_CYC = KK + NCH + 2;

  conv_state_e state_q, state_d;

  logic [TAP_W-1:0]  mac_tap_q;
  logic [CHW-1:0]    wr_ch_q;
  logic [TAP_W-1:0]  iss_idx_q;
  logic [JW-1:0]     iss_j_q;
  logic [IMG_AW-1:0] iss_off_q;
  logic [IMG_AW-1:0] base_q;
  logic [COL_W-1:0]  col_q;
  logic [WIN_AW-1:0] win_q;
  logic              last_win;
  logic              last_tap;
  logic              last_ch;
  logic              scan_clear;
  logic              scan_step;

  assign last_win   = (win_q == WIN_AW'(NWIN - 1));
  assign last_tap   = (mac_tap_q == TAP_W'(KK - 1));
  assign last_ch    = (wr_ch_q == CHW'(NCH - 1));
  assign scan_clear = (state_q == ST_IDLE) && start;
  assign scan_step  = (state_q == ST_STEP) && !last_win;

  // next-state logic
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start) state_d = ST_CLR;
      ST_CLR:  state_d = ST_MAC;
      ST_MAC:  if (last_tap) state_d = ST_WR;
      ST_WR:   if (last_ch) state_d = ST_STEP;
      ST_STEP: state_d = last_win ? ST_DONE : ST_CLR;
      ST_DONE: state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  // tap counter of the accumulate phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  mac_tap_q <= '0;
    else if (state_q == ST_CLR)  mac_tap_q <= '0;
    else if (state_q == ST_MAC)  mac_tap_q <= mac_tap_q + TAP_W'(1);
  end

  // channel counter of the write phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  wr_ch_q <= '0;
    else if (state_q == ST_MAC)  wr_ch_q <= '0;
    else if (state_q == ST_WR)   wr_ch_q <= wr_ch_q + CHW'(1);
  end

  // fetch pointer: runs one tap ahead of the accumulate phase
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iss_idx_q <= '0;
      iss_j_q   <= '0;
      iss_off_q <= '0;
    end else if (state_q == ST_IDLE || state_q == ST_STEP) begin
      iss_idx_q <= '0;
      iss_j_q   <= '0;
      iss_off_q <= '0;
    end else if (rd_en) begin
      iss_idx_q <= iss_idx_q + TAP_W'(1);
      if (iss_j_q == JW'(K - 1)) begin
        iss_j_q   <= '0;
        iss_off_q <= iss_off_q + IMG_AW'(IMG_W - K + 1);
      end else begin
        iss_j_q   <= iss_j_q + JW'(1);
        iss_off_q <= iss_off_q + IMG_AW'(1);
      end
    end
  end

  // raster position of the window
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      col_q  <= '0;
      win_q  <= '0;
    end else if (scan_clear) begin
      base_q <= '0;
      col_q  <= '0;
      win_q  <= '0;
    end else if (scan_step) begin
      win_q <= win_q + WIN_AW'(1);
      if (col_q == COL_W'(OW - 1)) begin
        col_q  <= '0;
        base_q <= base_q + IMG_AW'(K);
      end else begin
        col_q  <= col_q + COL_W'(1);
        base_q <= base_q + IMG_AW'(1);
      end
    end
  end

  assign rd_en    = (state_q == ST_CLR) || ((state_q == ST_MAC) && !last_tap);
  assign img_addr = base_q + iss_off_q;
  assign tap_idx  = iss_idx_q;
  assign mac_clr  = (state_q == ST_CLR);
  assign mac_en   = (state_q == ST_MAC);
  assign wr_en    = (state_q == ST_WR);
  assign wr_ch    = wr_ch_q;
  assign win_idx  = win_q;
  assign done     = (state_q == ST_DONE);

  // cycle count within a window, used only by the budget check
  logic [7:0] cyc_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 cyc_q <= '0;
    else if (state_q == ST_CLR) cyc_q <= 8'd1;
    else                        cyc_q <= cyc_q + 8'd1;
  end

  assert_rd_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(img_addr) < IMG_W * IMG_H));

  assert_tap_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |-> (32'(tap_idx) < KK));

  assert_window_budget_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STEP) |-> (32'(cyc_q) == WIN_CYC - 1));

  assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && state_q == ST_IDLE));

  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_MAC && start) |=> (state_q == ST_MAC || state_q == ST_WR));

endmodule

// File: rtl/conv_mac.sv
module conv_mac #(
  parameter int unsigned PIX_W = 8,
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACC_W = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    clr,
  input  logic                    en,
  input  logic [PIX_W-1:0]        pix,
  input  logic signed [WGT_W-1:0] wgt,
  output logic signed [ACC_W-1:0] acc
);

  localparam int unsigned PROD_W = PIX_W + WGT_W + 1;

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W:0]    sum_wide;
  logic signed [ACC_W-1:0]  acc_q;

  assign prod     = PROD_W'($signed({1'b0, pix})) * PROD_W'(wgt);
  assign sum_wide = (ACC_W+1)'(acc_q) + (ACC_W+1)'(prod);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   acc_q <= '0;
    else if (clr) acc_q <= '0;
    else if (en)  acc_q <= sum_wide[ACC_W-1:0];
  end

  assign acc = acc_q;

  assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
    en |-> (sum_wide[ACC_W] == sum_wide[ACC_W-1]));

  assert_clear_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));

endmodule

// File: rtl/conv_out_sel.sv
module conv_out_sel
  import conv_pkg::*;
#(
  parameter int unsigned NCH   = 3,
  parameter int unsigned NWIN  = 676,
  parameter int unsigned ACC_W = 20
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [clog2_min1(NCH)-1:0]        wr_ch,
  input  logic [clog2_min1(NWIN)-1:0]       win_idx,
  input  logic [NCH*ACC_W-1:0]              acc_flat,
  output logic [clog2_min1(NCH*NWIN)-1:0]   res_addr,
  output logic [ACC_W-1:0]                  res_data
);

  localparam int unsigned OUT_AW = clog2_min1(NCH * NWIN);

  assign res_addr = OUT_AW'(wr_ch) * OUT_AW'(NWIN) + OUT_AW'(win_idx);
  assign res_data = acc_flat[wr_ch*ACC_W +: ACC_W];

  assert_wr_addr_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(res_addr) < NCH * NWIN));

  assert_wr_channel_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (32'(wr_ch) < NCH));

endmodule

// File: rtl/conv3x3_engine.sv
module conv3x3_engine
  import conv_pkg::*;
#(
  parameter int unsigned IMG_W = 28,
  parameter int unsigned IMG_H = 28,
  parameter int unsigned K     = 3,
  parameter int unsigned NCH   = 3,
  parameter int unsigned PIX_W = 8,
  parameter int unsigned WGT_W = 8,
  parameter int unsigned ACC_W = 20
) (
  input  logic                                                   clk,
  input  logic                                                   rst_n,
  input  logic                                                   start,
  output logic                                                   img_rd,
  output logic [clog2_min1(IMG_W*IMG_H)-1:0]                     img_addr,
  input  logic [PIX_W-1:0]                                       img_rdata,
  output logic                                                   wgt_rd,
  output logic [clog2_min1(K*K+1)-1:0]                           wgt_addr,
  input  logic [NCH*WGT_W-1:0]                                   wgt_rdata,
  output logic                                                   res_we,
  output logic [clog2_min1(NCH*(IMG_W-K+1)*(IMG_H-K+1))-1:0]     res_addr,
  output logic [ACC_W-1:0]                                       res_data,
  output logic                                                   done
);

  localparam int unsigned NWIN   = (IMG_W - K + 1) * (IMG_H - K + 1);
  localparam int unsigned CHW    = clog2_min1(NCH);
  localparam int unsigned WIN_AW = clog2_min1(NWIN);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  logic              rd_en;
  logic              mac_clr;
  logic              mac_en;
  logic              wr_en;
  logic [CHW-1:0]    wr_ch;
  logic [WIN_AW-1:0] win_idx;
  logic [NCH*ACC_W-1:0] acc_flat;

  conv_ctrl #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .K     (K),
    .NCH   (NCH)
  ) u_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .start    (start),
    .rd_en    (rd_en),
    .img_addr (img_addr),
    .tap_idx  (wgt_addr),
    .mac_clr  (mac_clr),
    .mac_en   (mac_en),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .win_idx  (win_idx),
    .done     (done)
  );

  for (genvar ch = 0; ch < NCH; ch++) begin : g_lane
    logic signed [ACC_W-1:0] lane_acc;

    conv_mac #(
      .PIX_W (PIX_W),
      .WGT_W (WGT_W),
      .ACC_W (ACC_W)
    ) u_mac (
      .clk   (clk),
      .rst_n (rst_int_n),
      .clr   (mac_clr),
      .en    (mac_en),
      .pix   (img_rdata),
      .wgt   ($signed(wgt_rdata[ch*WGT_W +: WGT_W])),
      .acc   (lane_acc)
    );

    assign acc_flat[ch*ACC_W +: ACC_W] = lane_acc;
  end

  conv_out_sel #(
    .NCH   (NCH),
    .NWIN  (NWIN),
    .ACC_W (ACC_W)
  ) u_out (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .wr_en    (wr_en),
    .wr_ch    (wr_ch),
    .win_idx  (win_idx),
    .acc_flat (acc_flat),
    .res_addr (res_addr),
    .res_data (res_data)
  );

  assign img_rd = rd_en;
  assign wgt_rd = rd_en;
  assign res_we = wr_en;

  assert_no_read_and_write_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    !(img_rd && res_we));

  assert_done_quiet_R6: assert property (@(posedge clk) disable iff (!rst_int_n)
    done |-> (!img_rd && !res_we));

endmodule

// File: tb/conv3x3_engine_tb.sv
module conv3x3_engine_tb;

  localparam int IW   = 28;
  localparam int IH   = 28;
  localparam int K    = 3;
  localparam int NCH  = 3;
  localparam int OW   = IW - K + 1;
  localparam int OH   = IH - K + 1;
  localparam int KK   = K * K;
  localparam int NWIN = OW * OH;
  localparam int WC   = KK + NCH + 2;

  logic        clk;
  logic        rst_n;
  logic        start;
  logic        img_rd;
  logic [9:0]  img_addr;
  logic [7:0]  img_rdata;
  logic        wgt_rd;
  logic [3:0]  wgt_addr;
  logic [23:0] wgt_rdata;
  logic        res_we;
  logic [10:0] res_addr;
  logic [19:0] res_data;
  logic        done;

  logic [7:0]  img_mem [IW*IH];
  logic [23:0] wgt_mem [KK];

  int checks = 0;
  int errors = 0;
  int done_cnt = 0;
  int wr_cnt = 0;
  int cycles = 0;
  bit m_act = 0;
  int m_k = 0;

  conv3x3_engine u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .img_rd    (img_rd),
    .img_addr  (img_addr),
    .img_rdata (img_rdata),
    .wgt_rd    (wgt_rd),
    .wgt_addr  (wgt_addr),
    .wgt_rdata (wgt_rdata),
    .res_we    (res_we),
    .res_addr  (res_addr),
    .res_data  (res_data),
    .done      (done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // synchronous memories, one cycle of read latency
  always @(posedge clk) begin
    if (img_rd) img_rdata <= img_mem[int'(img_addr)];
    if (wgt_rd) wgt_rdata <= wgt_mem[int'(wgt_addr)];
  end

  function automatic int conv_ref(input int ch, input int r, input int c);
    int s = 0;
    for (int i = 0; i < K; i++)
      for (int j = 0; j < K; j++) begin
        logic [23:0] wv = wgt_mem[i*K + j];
        s += int'(img_mem[(r+i)*IW + c + j]) * int'($signed(wv[ch*8 +: 8]));
      end
    return s;
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference: cycle index since the start was accepted
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin
      m_act = 0;
      m_k = 0;
    end else if (m_act) begin
      if (m_k == NWIN*WC) m_act = 0;
      else m_k++;
    end else if (start) begin
      m_act = 1;
      m_k = 0;
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      bit e_rd, e_we, e_done;
      int e_addr, e_tap, e_waddr, e_wdata;
      e_rd = 0; e_we = 0; e_done = 0;
      e_addr = 0; e_tap = 0; e_waddr = 0; e_wdata = 0;
      if (m_act) begin
        if (m_k == NWIN*WC) e_done = 1;
        else begin
          int w, p, r, c;
          w = m_k / WC; p = m_k % WC; r = w / OW; c = w % OW;
          if (p < KK) begin
            e_rd = 1; e_tap = p;
            e_addr = (r + p / K) * IW + c + p % K;
          end else if (p > KK && p <= KK + NCH) begin
            e_we = 1;
            e_waddr = (p - KK - 1) * NWIN + w;
            e_wdata = conv_ref(p - KK - 1, r, c);
          end
        end
      end
      check(img_rd == e_rd && wgt_rd == e_rd, "R2 R5 read strobe", int'(img_rd), int'(e_rd));
      if (e_rd) begin
        check(int'(img_addr) == e_addr, "R2 image address", int'(img_addr), e_addr);
        check(int'(wgt_addr) == e_tap, "R2 weight tap", int'(wgt_addr), e_tap);
      end
      check(res_we == e_we, "R5 write strobe", int'(res_we), int'(e_we));
      if (e_we) begin
        check(int'(res_addr) == e_waddr, "R4 result address", int'(res_addr), e_waddr);
        check(int'($signed(res_data)) == e_wdata, "R3 R9 result value",
              int'($signed(res_data)), e_wdata);
      end
      check(done == e_done, "R6 done", int'(done), int'(e_done));
      if (done) done_cnt++;
      if (res_we) wr_cnt++;
    end
  end

  task automatic load_flat();
    for (int a = 0; a < IW*IH; a++) img_mem[a] = 8'd255;
    for (int t = 0; t < KK; t++) begin
      logic [7:0] w2;
      w2 = (t % 2 == 0) ? 8'sd127 : -8'sd128;
      wgt_mem[t] = {w2, 8'h80, 8'h7F};
    end
  endtask

  task automatic load_mixed();
    for (int y = 0; y < IH; y++)
      for (int x = 0; x < IW; x++)
        img_mem[y*IW + x] = 8'((x*7 + y*13 + x*y) & 255);
    for (int t = 0; t < KK; t++)
      for (int ch = 0; ch < NCH; ch++)
        wgt_mem[t][ch*8 +: 8] = 8'(((t*29 + ch*53 + 11) % 256) - 128);
  endtask

  task automatic run_pass(input string tag, input bit poke);
    int d0, w0;
    d0 = done_cnt; w0 = wr_cnt;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    if (poke) begin
      repeat (100*WC + 3) @(negedge clk);
      start = 1'b1;               // R7: start while busy
      @(negedge clk); start = 1'b0;
    end
    while (done_cnt == d0) @(negedge clk);
    repeat (20) @(negedge clk);
    check(done_cnt - d0 == 1, {tag, " single done"}, done_cnt - d0, 1);
    check(wr_cnt - w0 == NCH*NWIN, {tag, " write count"}, wr_cnt - w0, NCH*NWIN);
  endtask

  initial begin
    start = 1'b0;
    rst_n = 1'b0;
    load_flat();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (6) @(negedge clk);
    // R1: idle state after reset
    check(!img_rd && !wgt_rd && !res_we && !done, "R1 idle after reset",
          int'({img_rd, wgt_rd, res_we, done}), 0);
    run_pass("R7 R6", 1'b1);
    load_mixed();
    run_pass("R8", 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule